// File: doc/BRIEF.md
# Replacement Way Picker for a Set-Associative Cache

This block decides which way of an N-way set should receive a newly fetched line when a lookup misses. The cache controller presents the index of the addressed set together with that set's per-way valid bits, and the block answers in the same cycle with a way number and a flag telling whether that way is empty. If any way is empty, the lowest-numbered empty way is returned and the replacement policy plays no part. Only when every way holds a line does the block use the policy chosen by a two-bit select: a pseudo-random pick, true least-recently-used ordering, or load-order (first-in-first-out) rotation.

The controller reports cache activity through a separate update port: a hit strobe or a fill strobe, each naming a set and a way. The block keeps recency ranks and a rotation pointer for every set and updates them on every report, whatever policy is active. A change of policy therefore takes effect at once and uses the access history already recorded. The victim answer is a pure function of the current state and the lookup inputs, so it has no handshake. Every pin is a plain level signal and there is no back-pressure. Tag storage, data storage and the memory side are outside this block.

Top module: `repl_way_picker`

## Requirements
- R1: When at least one bit of `way_valid` is 0, `victim_way` is the lowest index whose valid bit is 0 and `victim_free` is 1. When all bits are 1, `victim_free` is 0.
- R2: With `policy_sel` = 2'b00, `victim_way` equals the low log2(WAYS) bits of a 16-bit shift register. The register is loaded with 16'hACE1 on reset and advances on every clock after reset to {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R3: With `policy_sel` = 2'b01, `victim_way` is the least recently touched way of the addressed set. A hit or a fill makes the named way the most recent. The other ways that were more recent than it move one step older.
- R4: With `policy_sel` = 2'b10, `victim_way` is the rotation pointer of the addressed set. Each fill to that set advances the pointer by one, wrapping from WAYS-1 to 0.
- R5: Hits never move the rotation pointer, so the victim chosen under `policy_sel` = 2'b10 stays the same across any number of hits.
- R6: A hit or fill to one set leaves the victim of every other set unchanged.
- R7: A cycle with both `hit_en` and `fill_en` high counts as a single fill: the pointer advances once and the named way becomes most recent.
- R8: The code `policy_sel` = 2'b11 behaves exactly like 2'b00.
- R9: After reset, every set has recency ranks equal to the way index, so the least recently used way is WAYS-1, and every rotation pointer is 0.
- R10: Recency and rotation state are updated under every policy, so the first lookup after a policy switch already reflects all earlier hits and fills.
- R11: With WAYS = 1, `victim_way` is always 0 and `victim_free` is the inverse of the single valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_sel | input | 2 | 00 random, 01 least recently used, 10 load order, 11 random |
| look_set | input | log2(SETS) | Set addressed by the current lookup |
| way_valid | input | WAYS | Valid bit of each way of the addressed set |
| hit_en | input | 1 | A hit occurred on `upd_set` / `upd_way` this cycle |
| fill_en | input | 1 | A line was loaded into `upd_set` / `upd_way` this cycle |
| upd_set | input | log2(SETS) | Set named by the hit or fill report |
| upd_way | input | log2(WAYS) (1 if WAYS = 1) | Way named by the hit or fill report |
| victim_way | output | log2(WAYS) (1 if WAYS = 1) | Way chosen to receive the next line |
| victim_free | output | 1 | The chosen way is currently empty |

## Verification
The assertions assume that `upd_way` names an existing way and that the controller reports at most one set per cycle. They also assume that a report to a set is reflected in the next lookup of that set and in nothing else. The stimulus draws every update way and set index from its legal range. It holds `way_valid` all ones in most cycles so that the policy paths are exercised, and it keeps the set range small so that hits and fills often land on the set being looked up. Directed sequences cover the reset order, pointer wrap-around, simultaneous hit and fill, policy switches, and a one-way instance.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic [1:0] {
    POL_RAND = 2'b00,
    POL_LRU  = 2'b01,
    POL_FIFO = 2'b10,
    POL_ALT  = 2'b11
  } repl_pol_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] state
);
  logic feedback;

  assign feedback = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[14:0], feedback};
  end
endmodule

// File: rtl/repl_lru_bank.sv
module repl_lru_bank #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [SW-1:0] upd_set,
  input  logic [WW-1:0] upd_way,
  input  logic [SW-1:0] rd_set,
  output logic [WW-1:0] oldest_way
);
  localparam logic [WW-1:0] OLDEST_RANK = WW'(WAYS - 1);

  logic [WAYS-1:0][WW-1:0] ranks [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0][WW-1:0] rank_q;
    logic                    touch_here;
    logic [WW-1:0]           touched_rank;

    assign touch_here   = upd_en && (upd_set == SW'(s));
    assign touched_rank = rank_q[upd_way];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WAYS; w++) rank_q[w] <= WW'(w);
      end else if (touch_here) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WW'(w) == upd_way)            rank_q[w] <= '0;
          else if (rank_q[w] < touched_rank) rank_q[w] <= rank_q[w] + 1'b1;
        end
      end
    end

    assign ranks[s] = rank_q;
  end

  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (ranks[rd_set][w] == OLDEST_RANK) oldest_way = WW'(w);
    end
  end
endmodule

// File: rtl/repl_fifo_bank.sv
module repl_fifo_bank #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_en,
  input  logic [SW-1:0] fill_set,
  input  logic [SW-1:0] rd_set,
  output logic [WW-1:0] next_way
);
  localparam logic [WW-1:0] LAST_WAY = WW'(WAYS - 1);

  logic [WW-1:0] ptrs [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q <= '0;
      end else if (fill_en && (fill_set == SW'(s))) begin
        ptr_q <= (ptr_q == LAST_WAY) ? '0 : ptr_q + 1'b1;
      end
    end

    assign ptrs[s] = ptr_q;
  end

  assign next_way = ptrs[rd_set];
endmodule

// File: rtl/repl_way_picker.sv
module repl_way_picker
  import repl_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      policy_sel,
  input  logic [SW-1:0]   look_set,
  input  logic [WAYS-1:0] way_valid,
  input  logic            hit_en,
  input  logic            fill_en,
  input  logic [SW-1:0]   upd_set,
  input  logic [WW-1:0]   upd_way,
  output logic [WW-1:0]   victim_way,
  output logic            victim_free
);
  repl_pol_e     policy;
  logic [15:0]   lfsr_q;
  logic [WW-1:0] rand_way;
  logic [WW-1:0] lru_way;
  logic [WW-1:0] fifo_way;
  logic [WW-1:0] free_way;
  logic          free_any;
  logic          touch;

  assign policy = repl_pol_e'(policy_sel);
  assign touch  = hit_en | fill_en;

  repl_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (lfsr_q)
  );

  if (WAYS > 1) begin : g_rand_multi
    assign rand_way = lfsr_q[WW-1:0];
  end else begin : g_rand_single
    assign rand_way = '0;
  end

  repl_lru_bank #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (touch),
    .upd_set    (upd_set),
    .upd_way    (upd_way),
    .rd_set     (look_set),
    .oldest_way (lru_way)
  );

  repl_fifo_bank #(.WAYS(WAYS), .SETS(SETS)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_en  (fill_en),
    .fill_set (upd_set),
    .rd_set   (look_set),
    .next_way (fifo_way)
  );

  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) begin
        free_any = 1'b1;
        free_way = WW'(w);
      end
    end
  end

  always_comb begin
    if (free_any) begin
      victim_way = free_way;
    end else begin
      unique case (policy)
        POL_LRU:  victim_way = lru_way;
        POL_FIFO: victim_way = fifo_way;
        default:  victim_way = rand_way;
      endcase
    end
  end

  assign victim_free = free_any;
endmodule

// File: rtl/repl_way_picker_chk.sv
module repl_way_picker_chk #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      policy_sel,
  input logic [SW-1:0]   look_set,
  input logic [WAYS-1:0] way_valid,
  input logic            hit_en,
  input logic            fill_en,
  input logic [SW-1:0]   upd_set,
  input logic [WW-1:0]   upd_way,
  input logic [WW-1:0]   victim_way,
  input logic            victim_free
);
  logic [WAYS-1:0] below_mask;
  logic            all_valid;
  logic            multi;

  assign below_mask = (WAYS'(1) << victim_way) - WAYS'(1);
  assign all_valid  = &way_valid;
  assign multi      = (WAYS > 1);

  // R1: lowest empty way wins
  a_r1_lowest_free: assert property (@(posedge clk) disable iff (!rst_n)
    !all_valid |-> (victim_free && !way_valid[victim_way] && ((way_valid & below_mask) == below_mask)));

  // R1: no empty way reported when the set is full
  a_r1_full_not_free: assert property (@(posedge clk) disable iff (!rst_n)
    all_valid |-> !victim_free);

  // R5: without fills the rotation victim of a full set holds
  a_r5_fifo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_sel == 2'b10 && all_valid && !fill_en) |=>
    (!(policy_sel == 2'b10 && all_valid && look_set == $past(look_set)) || victim_way == $past(victim_way)));

  // R4: a fill to the looked-up set moves the rotation victim by one
  a_r4_fifo_step: assert property (@(posedge clk) disable iff (!rst_n)
    (multi && policy_sel == 2'b10 && all_valid && fill_en && upd_set == look_set) |=>
    (!(policy_sel == 2'b10 && all_valid && look_set == $past(look_set)) || victim_way == WW'($past(victim_way) + 1'b1)));

  // R3: a just-touched way is never the least recent one
  a_r3_touched_not_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (multi && (hit_en || fill_en)) |=>
    (!(policy_sel == 2'b01 && all_valid && look_set == $past(upd_set)) || victim_way != $past(upd_way)));

  // R11: single-way instance always answers way 0
  a_r11_single_way: assert property (@(posedge clk) disable iff (!rst_n)
    multi || (victim_way == '0));
endmodule

bind repl_way_picker repl_way_picker_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .policy_sel  (policy_sel),
  .look_set    (look_set),
  .way_valid   (way_valid),
  .hit_en      (hit_en),
  .fill_en     (fill_en),
  .upd_set     (upd_set),
  .upd_way     (upd_way),
  .victim_way  (victim_way),
  .victim_free (victim_free)
);

// File: tb/sim_repl_way_picker.sv
`timescale 1ns/1ps
module sim_repl_way_picker;
  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int WW   = 2;
  localparam int SW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    policy_sel = 2'b00;
  logic [SW-1:0] look_set = '0;
  logic [WAYS-1:0] way_valid = '1;
  logic          hit_en = 1'b0;
  logic          fill_en = 1'b0;
  logic [SW-1:0] upd_set = '0;
  logic [WW-1:0] upd_way = '0;
  logic [WW-1:0] victim_way;
  logic          victim_free;
  logic          v1_way;
  logic          v1_free;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  repl_way_picker #(.WAYS(WAYS), .SETS(SETS)) u0 (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .look_set(look_set),
    .way_valid(way_valid), .hit_en(hit_en), .fill_en(fill_en),
    .upd_set(upd_set), .upd_way(upd_way),
    .victim_way(victim_way), .victim_free(victim_free)
  );

  repl_way_picker #(.WAYS(1), .SETS(2)) u1 (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .look_set(look_set[0]),
    .way_valid(way_valid[0]), .hit_en(hit_en), .fill_en(fill_en),
    .upd_set(upd_set[0]), .upd_way(1'b0),
    .victim_way(v1_way), .victim_free(v1_free)
  );

  // Reference model built from the requirements
  int          m_rank [SETS][WAYS];
  int          m_ptr  [SETS];
  logic [15:0] m_lfsr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) m_rank[s][w] = w;
        m_ptr[s] = 0;
      end
      m_lfsr = 16'hACE1;
    end else begin
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
      if (hit_en || fill_en) begin
        int acc;
        acc = m_rank[upd_set][upd_way];
        for (int w = 0; w < WAYS; w++) begin
          if (w == int'(upd_way))         m_rank[upd_set][w] = 0;
          else if (m_rank[upd_set][w] < acc) m_rank[upd_set][w] = m_rank[upd_set][w] + 1;
        end
      end
      if (fill_en) m_ptr[upd_set] = (m_ptr[upd_set] + 1) % WAYS;
    end
  end

  function automatic int exp_victim();
    for (int w = 0; w < WAYS; w++) if (!way_valid[w]) return w;
    case (policy_sel)
      2'b01: begin
        for (int w = 0; w < WAYS; w++) if (m_rank[look_set][w] == WAYS - 1) return w;
        return 0;
      end
      2'b10:   return m_ptr[look_set];
      default: return int'(m_lfsr[WW-1:0]);
    endcase
  endfunction

  function automatic string req_tag();
    if (!(&way_valid)) return "R1";
    case (policy_sel)
      2'b01:   return "R3";
      2'b10:   return "R4";
      2'b11:   return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle of inputs on the falling edge, then compare the answer.
  task automatic step(logic [1:0] pol, int lset, logic [WAYS-1:0] vld,
                      bit hit, bit fill, int uset, int uway, string req);
    @(negedge clk);
    policy_sel = pol;
    look_set   = SW'(lset);
    way_valid  = vld;
    hit_en     = hit;
    fill_en    = fill;
    upd_set    = SW'(uset);
    upd_way    = WW'(uway);
    #2;
    check(req, int'(victim_way), exp_victim());
    check(req, int'(victim_free), int'(!(&vld)));
    check("R11", int'(v1_way), 0);
    check("R11", int'(v1_free), int'(!vld[0]));
  endtask

  task automatic look(logic [1:0] pol, int lset, string req);
    step(pol, lset, '1, 0, 0, 0, 0, req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: reset order, least recent is WAYS-1, pointer 0
    look(2'b01, 0, "R9");
    check("R9", int'(victim_way), WAYS - 1);
    look(2'b10, 9, "R9");
    check("R9", int'(victim_way), 0);

    // R1: lowest empty way regardless of policy
    step(2'b01, 0, 4'b1010, 0, 0, 0, 0, "R1");
    check("R1", int'(victim_way), 0);
    step(2'b10, 0, 4'b1011, 0, 0, 0, 0, "R1");
    check("R1", int'(victim_way), 2);
    step(2'b00, 0, 4'b0111, 0, 0, 0, 0, "R1");
    check("R1", int'(victim_way), 3);

    // R4: fills walk the pointer and wrap
    for (int i = 1; i <= 5; i++) begin
      step(2'b10, 5, '1, 0, 1, 5, 0, "R4");
      look(2'b10, 5, "R4");
      check("R4", int'(victim_way), i % WAYS);
    end

    // R5: hits leave the rotation untouched
    for (int i = 0; i < 4; i++) step(2'b10, 5, '1, 1, 0, 5, i, "R5");
    look(2'b10, 5, "R5");
    check("R5", int'(victim_way), 1);

    // R6: other sets unaffected
    look(2'b10, 6, "R6");
    check("R6", int'(victim_way), 0);
    look(2'b01, 6, "R6");
    check("R6", int'(victim_way), 3);

    // R3: touches 3, 0, 2 leave way 1 least recent
    step(2'b01, 2, '1, 1, 0, 2, 3, "R3");
    step(2'b01, 2, '1, 0, 1, 2, 0, "R3");
    step(2'b01, 2, '1, 1, 0, 2, 2, "R3");
    look(2'b01, 2, "R3");
    check("R3", int'(victim_way), 1);

    // R7: hit and fill together count as one fill
    step(2'b10, 8, '1, 1, 1, 8, 1, "R7");
    look(2'b10, 8, "R7");
    check("R7", int'(victim_way), 1);
    look(2'b01, 8, "R7");
    check("R7", int'(victim_way), 3);

    // R10: history recorded under random policy is used after a switch
    step(2'b00, 7, '1, 1, 0, 7, 3, "R10");
    step(2'b00, 7, '1, 1, 0, 7, 2, "R10");
    step(2'b00, 7, '1, 0, 1, 7, 1, "R10");
    look(2'b01, 7, "R10");
    check("R10", int'(victim_way), 0);
    look(2'b10, 7, "R10");
    check("R10", int'(victim_way), 1);

    // R2 and R8: generator-driven choice
    for (int i = 0; i < 8; i++) look(2'b00, 3, "R2");
    for (int i = 0; i < 8; i++) look(2'b11, 3, "R8");

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [WAYS-1:0] vld;
      logic [1:0]      pol;
      int              lset;
      bit              h, f;
      vld  = ($urandom % 4 == 0) ? WAYS'($urandom) : '1;
      pol  = 2'($urandom);
      lset = $urandom % 4;
      h    = ($urandom % 3 == 0);
      f    = ($urandom % 4 == 0);
      @(negedge clk);
      policy_sel = pol;
      look_set   = SW'(lset);
      way_valid  = vld;
      #1;
      step(pol, lset, vld, h, f, $urandom % 4, $urandom % WAYS, req_tag());
    end

    @(negedge clk);
    hit_en  = 1'b0;
    fill_en = 1'b0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule